// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port Controller

This block gives a CPU three byte-wide registers on a simple register bus to run eight general-purpose pins: a data latch, a direction register and a pull-device control register. From them it produces, per pin, an output enable, an output level and a pull-device enable for the pad ring. Reads of the data address return the synchronized pin level for input pins and the latch contents for output pins.

The two top pins (6 and 7) are open-drain. A 0 drives them low, and a 1 releases the line. They also raise a slow-falling-edge control line when an external enable bit is set and the pin is an output. Pins 0 to 3 and pin 7 are forwarded, after synchronization, to an interrupt request bus.

Top module: `gpio_port`

## Requirements
- R1: The data latch is at byte address 0x00, the direction register at 0x04 and the pull-device register at 0x10. A write with `bus_wr` high takes effect at the next rising clock edge.
- R2: A direction bit of 1 makes its pin an output and a 0 makes it an input. For pins 0 to 5, `pin_oe[i]` equals the direction bit.
- R3: Reset clears the direction and pull-device registers. While and after reset, `pin_oe` is 0x00 and `pull_en` is 0xFF.
- R4: Reset leaves the data latch unchanged. A value written before reset reads back at 0x00 once the pins are made outputs again.
- R5: For output pins 0 to 5, `pin_out[i]` equals the data latch bit.
- R6: A read of 0x00 returns the latch bit for output pins. For input pins it returns the pin level after a two-flop synchronizer, so it shows the level sampled two rising edges earlier and not the level sampled one edge earlier. A read of 0x04 returns the direction register.
- R7: Pins 6 and 7 are open-drain. `pin_out[7:6]` is always 0, and `pin_oe[i]` is 1 only when the pin is an output and its latch bit is 0.
- R8: `slow_fall[0]` (pin 6) and `slow_fall[1]` (pin 7) are 1 exactly when `slow_edge_en` is 1 and that pin is an output.
- R9: `irq_req[3:0]` carries the synchronized levels of pins 3..0, and `irq_req[4]` carries the synchronized level of pin 7.
- R10: The pull-device register is write-only, so a read of 0x10 returns 0. Reads of any address other than 0x00 and 0x04 return 0.
- R11: `pull_en[i]` is 1 only while pin i is an input and its pull-register bit is 0. Writing 1 to the pull-register bit turns the pull device off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| slow_edge_en | input | 1 | External slow-fall enable bit |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output-driver enable |
| pin_out | output | 8 | Per-pin driven level |
| pull_en | output | 8 | Per-pin pull-device enable |
| slow_fall | output | 2 | Slow-falling-edge control for pins 6 and 7 |
| irq_req | output | 5 | Synchronized pins {7,3,2,1,0} to the interrupt logic |

## Verification
Register writes affect `pin_oe`, `pin_out`, `pull_en` and `slow_fall` one rising edge after the strobe. Changes on `pin_in` reach the 0x00 read-back and `irq_req` two rising edges later. The bench changes inputs on falling edges and samples at the falling edge that follows the relevant rising edge. For the synchronizer it checks both the stale value after one edge and the fresh value after two. Read data is combinational, so it is sampled shortly after the address settles. The sweep runs through all 256 direction patterns, with data, pull and pin values derived from each one.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int AW = 8,
  parameter logic [AW-1:0] A_DAT  = 'h00,
  parameter logic [AW-1:0] A_DIR  = 'h04,
  parameter logic [AW-1:0] A_PULL = 'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          slow_edge_en,
  input  logic [7:0]    pin_in,
  output logic [7:0]    pin_oe,
  output logic [7:0]    pin_out,
  output logic [7:0]    pull_en,
  output logic [1:0]    slow_fall,
  output logic [4:0]    irq_req
);
  logic [7:0] dat_q, dir_q, pull_q, s1_q, s2_q;

  wire wr_dat  = bus_wr && (bus_addr == A_DAT);
  wire wr_dir  = bus_wr && (bus_addr == A_DIR);
  wire wr_pull = bus_wr && (bus_addr == A_PULL);

  always_ff @(posedge clk)
    if (wr_dat) dat_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q  <= '0;
      pull_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_pull) pull_q <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end

  assign pin_oe    = {dir_q[7:6] & ~dat_q[7:6], dir_q[5:0]};
  assign pin_out   = {2'b00, dat_q[5:0]};
  assign pull_en   = ~dir_q & ~pull_q;
  assign slow_fall = {2{slow_edge_en}} & dir_q[7:6];
  assign irq_req   = {s2_q[7], s2_q[3:0]};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_DAT)      bus_rdata = (dir_q & dat_q) | (~dir_q & s2_q);
    else if (bus_addr == A_DIR) bus_rdata = dir_q;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       slow_edge_en,
  input logic [7:0] pin_in,
  input logic [7:0] pin_oe,
  input logic [7:0] pin_out,
  input logic [7:0] pull_en,
  input logic [1:0] slow_fall,
  input logic [4:0] irq_req
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  p_reset_r3: assert property (@(posedge clk) !rst_n |=> (pin_oe == 8'h00 && pull_en == 8'hFF));
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04) |=> pin_oe[5:0] == $past(bus_wdata[5:0]));
  p_open_drain_r7: assert property (@(posedge clk) disable iff (!rst_n) pin_out[7:6] == 2'b00);
  p_slow_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_fall != 2'b00) |-> slow_edge_en);
  p_pull_off_out_r11: assert property (@(posedge clk) disable iff (!rst_n) (pull_en & pin_oe) == 8'h00);
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 8'h00 && bus_addr != 8'h04) |-> bus_rdata == 8'h00);
  p_irq_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> irq_req == {$past(pin_in[7], 2), $past(pin_in[3:0], 2)});
endmodule

bind gpio_port gpio_port_chk chk (.*);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic clk = 0, rst_n = 0, bus_wr = 0, slow_edge_en = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, pin_in = 0;
  logic [7:0] bus_rdata, pin_oe, pin_out, pull_en;
  logic [1:0] slow_fall;
  logic [4:0] irq_req;
  int errors = 0, checks = 0;

  gpio_port dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk(pin_oe, 8'h00, "R3 oe in reset");
    chk(pull_en, 8'hFF, "R3 pull in reset");
    rst_n = 1;
    @(negedge clk);
    rd(8'h04, r); chk(r, 8'h00, "R3 dir after reset");

    // R4: latch survives reset
    wr(8'h00, 8'h2D);
    wr(8'h04, 8'hFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(pin_oe, 8'h00, "R3 oe after reset");
    rst_n = 1;
    wr(8'h04, 8'hFF);
    rd(8'h00, r); chk(r, 8'h2D, "R4 latch kept");
    chk(pin_out, 8'h2D, "R5 out after reset");

    // R10 reads
    wr(8'h10, 8'hA5);
    rd(8'h10, r); chk(r, 8'h00, "R10 pull unreadable");
    rd(8'h01, r); chk(r, 8'h00, "R10 unmapped");
    rd(8'hFF, r); chk(r, 8'h00, "R10 unmapped high");

    // R6 synchronizer timing
    wr(8'h04, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hB6;
    @(negedge clk);
    rd(8'h00, r); chk(r, 8'h00, "R6 one edge stale");
    chk({3'b000, irq_req}, 8'h00, "R9 one edge stale");
    @(negedge clk);
    rd(8'h00, r); chk(r, 8'hB6, "R6 two edges fresh");
    chk({3'b000, irq_req}, {3'b000, 1'b1, 4'h6}, "R9 two edges fresh");

    // Sweep all direction patterns
    for (int i = 0; i < 256; i++) begin
      logic [7:0] dir, dat, pul, pin, eoe, eread;
      dir = 8'(i); dat = dir ^ 8'h5A; pul = {dir[0], dir[7:1]} ^ 8'h0F; pin = ~dir ^ 8'h33;
      slow_edge_en = i[0] ^ i[3];
      wr(8'h00, dat);
      wr(8'h10, pul);
      wr(8'h04, dir);
      pin_in = pin;
      rd(8'h04, r); chk(r, dir, "R1 R6 dir readback");
      eoe = {dir[7:6] & ~dat[7:6], dir[5:0]};
      chk(pin_oe, eoe, "R2 R7 oe");
      chk(pin_out & {2'b00, dir[5:0]}, dat & {2'b00, dir[5:0]}, "R5 out");
      chk(pin_out & 8'hC0, 8'h00, "R7 od level");
      chk(pull_en, ~dir & ~pul, "R11 pull");
      chk({6'b0, slow_fall}, {6'b0, dir[7:6] & {2{slow_edge_en}}}, "R8 slow fall");
      repeat (2) @(negedge clk);
      eread = (dir & dat) | (~dir & pin);
      rd(8'h00, r); chk(r, eread, "R6 data read");
      chk({3'b000, irq_req}, {3'b000, pin[7], pin[3:0]}, "R9 irq");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule